// File: doc/BRIEF.md
# Second-Order Fixed-Point Plant Model

This block is a hardware stand-in for a second-order discrete-time plant, intended to close a control loop in simulation: a controller drives the plant input, and the plant output is fed back to form the error term. Each time a sample strobe arrives, the block combines the new input, the two previous inputs and the two previous outputs through a recursive direct-form-I difference equation. It then registers the result as the new plant output.

All values are Q15 signed 16-bit numbers, so a half-scale input such as a 0.5 step is the code 16384. The coefficient set is fixed and pre-scaled by one half. The weighted sum is therefore doubled before it is brought back from Q30 to Q15. With this scaling the DC gain is one. The output holds between strobes and is qualified by a one-cycle valid pulse.

Top module: `plant_iir2`

## Requirements
- R1: A synchronous reset clears both stored inputs and both stored outputs to zero, drives `plantOut` to 0 and `plantValid` to 0.
- R2: On a strobe, the block forms the weighted sum S = 31048·y(n−1) − 14828·y(n−2) + 42·x(n) + 80·x(n−1) + 42·x(n−2). Here x(n) is `ctrlIn` and y(n−1) is the current `plantOut`.
- R3: The new output is floor(2·S / 2^15), which is S shifted right arithmetically by 14 bits, so rounding is toward negative infinity.
- R4: A scaled result above 32767 is clipped to 32767, and one below −32768 is clipped to −32768. The clipped value is what enters the output history.
- R5: On each strobe the history shifts: x(n−2) takes x(n−1), x(n−1) takes x(n), y(n−2) takes y(n−1), and y(n−1) takes the new output.
- R6: `plantValid` is high in exactly the cycle after a cycle with `sampleStrobe` high, and low otherwise.
- R7: `plantOut` changes only in the cycle after a strobe, and holds its value while no strobe arrives.
- R8: With a constant input of 16384, the output settles within 128 LSB of 16384, bounded by the floor-rounding deadband, and stays there.
- R9: `ctrlIn` has no effect on the output or on the stored history while `sampleStrobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sampleStrobe | input | 1 | Marks the cycle in which `ctrlIn` is a new plant input sample |
| ctrlIn | input | 16 | Plant input x(n), signed Q15 |
| plantOut | output | 16 | Plant output y(n), signed Q15, held between samples |
| plantValid | output | 1 | One-cycle pulse marking a fresh `plantOut` |

## Verification
The hardest condition to reach from the ports is output clipping. It only occurs once the stored outputs sit near one rail and the input then jumps to the other rail, so that the lightly damped response overshoots past full scale. The stimulus first holds the input at −32768 for several hundred samples to load the history, then applies 32767 and follows the ringing through a bit-exact reference model. The floor-rounding deadband near the settled value is reached the same way, with a long 16384 step. Junk values on `ctrlIn` between strobes show whether the unqualified input leaks into the history.

// File: rtl/plant_iir2_pkg.sv
package plant_iir2_pkg;

  // Strobes from the sequencer into the arithmetic path
  typedef struct packed {
    logic advance;   // take a new sample and shift the history
    logic announce;  // result registered this cycle is fresh
  } plantCtl_t;

  localparam int TAP_COUNT = 5;

endpackage

// File: rtl/plant_iir2_ctrl.sv
module plant_iir2_ctrl
  import plant_iir2_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleStrobe,
  output plantCtl_t ctl,
  output logic      plantValid
);

  logic validReg;

  always_comb begin
    ctl.advance  = sampleStrobe & ~rst;
    ctl.announce = sampleStrobe & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validReg <= 1'b0;
    else     validReg <= ctl.announce;
  end

  assign plantValid = validReg;

  // R6: a strobe is answered by valid one cycle later
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> plantValid);

  // R6: no valid pulse without a strobe in the previous cycle
  assert_valid_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !sampleStrobe |=> !plantValid);

endmodule

// File: rtl/plant_iir2_dp.sv
module plant_iir2_dp
  import plant_iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 15,
  parameter int ACC_W  = 40,
  parameter int COEF_Y1 = 31048,
  parameter int COEF_Y2 = -14828,
  parameter int COEF_X0 = 42,
  parameter int COEF_X1 = 80,
  parameter int COEF_X2 = 42
) (
  input  logic                     clk,
  input  logic                     rst,
  input  plantCtl_t                ctl,
  input  logic signed [DATA_W-1:0] ctrlIn,
  output logic signed [DATA_W-1:0] plantOut
);

  // Halved coefficients: doubling then dropping FRAC_W bits is one shift of FRAC_W-1
  localparam int SHIFT = FRAC_W - 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -(ACC_W'(1) <<< (DATA_W - 1));
  localparam int COEFS [TAP_COUNT] = '{COEF_X0, COEF_X1, COEF_X2, COEF_Y1, COEF_Y2};

  logic signed [DATA_W-1:0] inHist1, inHist2, outHist1, outHist2;
  logic signed [DATA_W-1:0] tapVal [TAP_COUNT];
  logic signed [ACC_W-1:0]  tapProd [TAP_COUNT];
  logic signed [ACC_W-1:0]  accSum;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [DATA_W-1:0] nextOut;

  always_comb begin
    tapVal[0] = ctrlIn;
    tapVal[1] = inHist1;
    tapVal[2] = inHist2;
    tapVal[3] = outHist1;
    tapVal[4] = outHist2;
  end

  for (genvar t = 0; t < TAP_COUNT; t++) begin : g_tap
    logic signed [ACC_W-1:0] coefWide;
    logic signed [ACC_W-1:0] dataWide;
    assign coefWide   = ACC_W'(COEFS[t]);
    assign dataWide   = ACC_W'(tapVal[t]);
    assign tapProd[t] = dataWide * coefWide;
  end

  always_comb begin
    accSum = '0;
    for (int t = 0; t < TAP_COUNT; t++) accSum = accSum + tapProd[t];
  end

  always_comb begin
    scaled = accSum >>> SHIFT;
    if (scaled > SAT_HI)      nextOut = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) nextOut = SAT_LO[DATA_W-1:0];
    else                      nextOut = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inHist1  <= '0;
      inHist2  <= '0;
      outHist1 <= '0;
      outHist2 <= '0;
    end else if (ctl.advance) begin
      inHist1  <= ctrlIn;
      inHist2  <= inHist1;
      outHist1 <= nextOut;
      outHist2 <= outHist1;
    end
  end

  assign plantOut = outHist1;

  // R5: history moves one place per accepted sample
  assert_shift_input_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> (inHist1 == $past(ctrlIn)) && (inHist2 == $past(inHist1)));

  assert_shift_output_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> outHist2 == $past(outHist1));

  // R7 / R9: nothing moves without a sample
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl.advance |=> $stable(plantOut) && $stable(inHist1) && $stable(outHist2));

  // R4: a clipped result lands exactly on a rail
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && (scaled > SAT_HI)) |=> plantOut == SAT_HI[DATA_W-1:0]);

endmodule

// File: rtl/plant_iir2.sv
module plant_iir2
  import plant_iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 15,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleStrobe,
  input  logic signed [DATA_W-1:0] ctrlIn,
  output logic signed [DATA_W-1:0] plantOut,
  output logic                     plantValid
);

  plantCtl_t ctl;

  plant_iir2_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .ctl          (ctl),
    .plantValid   (plantValid)
  );

  plant_iir2_dp #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .ctrlIn   (ctrlIn),
    .plantOut (plantOut)
  );

endmodule

// File: tb/sim_plant_iir2.sv
module sim_plant_iir2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sampleStrobe = 1'b0;
  logic signed [15:0] ctrlIn = '0;
  logic signed [15:0] plantOut;
  logic               plantValid;

  int checks = 0;
  int fails  = 0;
  bit summaryDone = 0;

  always #4 clk = ~clk;

  plant_iir2 u0 (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .ctrlIn       (ctrlIn),
    .plantOut     (plantOut),
    .plantValid   (plantValid)
  );

  localparam int NVEC = 20;
  localparam logic signed [15:0] STIM [NVEC] = '{
    16'sd16384, 16'sd16384, 16'sd16384, 16'sd0, -16'sd16384,
    16'sd32767, -16'sd32768, 16'sd1, -16'sd1, 16'sd1000,
    16'sd12345, -16'sd777, 16'sd20000, 16'sd20000, -16'sd5,
    16'sd300, -16'sd9000, 16'sd32767, 16'sd32767, 16'sd0
  };

  // Reference history, written from the requirements
  longint mx1, mx2, my1, my2;

  function automatic longint refStep(input longint x);
    longint s, q;
    s = 31048 * my1 - 14828 * my2 + 42 * x + 80 * mx1 + 42 * mx2;   // R2
    q = s >>> 14;                                                    // R3
    if (q > 32767) q = 32767;                                        // R4
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic refClear();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endtask

  // Drive one sample, check the response, return the output
  task automatic sample(input logic signed [15:0] x, input string req, output longint y);
    longint e;
    @(negedge clk);
    ctrlIn = x;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    e = refStep(longint'(x));
    check(plantValid == 1'b1, "R6", longint'(plantValid), 1);
    check(longint'(plantOut) == e, req, longint'(plantOut), e);
    mx2 = mx1; mx1 = longint'(x); my2 = my1; my1 = e;   // R5
    y = longint'(plantOut);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    longint y, held;
    bit sawRail;
    refClear();
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(plantOut == 16'sd0, "R1", longint'(plantOut), 0);
    check(plantValid == 1'b0, "R1", longint'(plantValid), 0);

    // Table walk: R2, R3 (negative values exercise floor rounding)
    for (int i = 0; i < NVEC; i++) sample(STIM[i], "R2_R3", y);

    // R6 / R7: valid drops and output holds with no strobe
    held = longint'(plantOut);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(plantValid == 1'b0, "R6", longint'(plantValid), 0);
      check(longint'(plantOut) == held, "R7", longint'(plantOut), held);
    end

    // R9: junk on the input while idle must not reach the history
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ctrlIn = 16'(i * 9001 - 20000);
      check(longint'(plantOut) == held, "R9", longint'(plantOut), held);
    end
    sample(16'sd5000, "R9", y);
    sample(16'sd5000, "R5", y);

    // R6: back-to-back strobes, one pulse per sample
    @(negedge clk);
    ctrlIn = 16'sd100; sampleStrobe = 1'b1;
    @(negedge clk);
    check(plantValid == 1'b1, "R6", longint'(plantValid), 1);
    check(longint'(plantOut) == refStep(100), "R5", longint'(plantOut), refStep(100));
    y = refStep(100); mx2 = mx1; mx1 = 100; my2 = my1; my1 = y;
    ctrlIn = -16'sd100;
    @(negedge clk);
    sampleStrobe = 1'b0;
    check(plantValid == 1'b1, "R6", longint'(plantValid), 1);
    check(longint'(plantOut) == refStep(-100), "R5", longint'(plantOut), refStep(-100));
    y = refStep(-100); mx2 = mx1; mx1 = -100; my2 = my1; my1 = y;
    @(negedge clk);
    check(plantValid == 1'b0, "R6", longint'(plantValid), 0);

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    refClear();
    check(plantOut == 16'sd0, "R1", longint'(plantOut), 0);
    check(plantValid == 1'b0, "R1", longint'(plantValid), 0);

    // R8: half-scale step settles close to unity gain
    for (int i = 0; i < 500; i++) sample(16'sd16384, "R8", y);
    check((y >= 16384 - 128) && (y <= 16384 + 128), "R8", y, 16384);
    held = y;
    for (int i = 0; i < 20; i++) sample(16'sd16384, "R8", y);
    check(y == held, "R8", y, held);

    // R4: park at the negative rail, then step to the positive rail
    for (int i = 0; i < 400; i++) sample(-16'sd32768, "R4", y);
    sawRail = 0;
    for (int i = 0; i < 80; i++) begin
      sample(16'sd32767, "R4", y);
      if (y == 32767) sawRail = 1;
    end
    check(sawRail, "R4", longint'(sawRail), 1);

    summaryDone = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule